// File: doc/BRIEF.md
# Audio CPU Address Decoder with Boot ROM Overlay

This block sits between an 8-bit audio processor and the 64 KB memory space that the processor shares with the sound DSP. On each access it sends the bus to one of three places:

- a sixteen-entry hardware register page at 0x00F0–0x00FF;
- a 64-byte boot ROM that can shadow the top of memory;
- the external RAM array.

The RAM array is synchronous. Its address and strobes pass straight through the block. Read data from every target returns one cycle after the read strobe, on `cpu_rdata`, qualified by `cpu_rvalid`.

The register page holds four things:

- a control register, which drives the three timer enables and the boot ROM enable and which can clear inbound port pairs;
- an indirect window into the DSP register file, made of an index latch and a data port;
- four communication ports, each with its own CPU-to-host and host-to-CPU byte;
- a test register that takes writes and does nothing with them.

A host interface loads the inbound bytes. The outbound bytes are presented in parallel.

Top module: `snd_bus_decoder`

## Requirements
- R1: Synchronous reset drives the timer enables to 0, turns the boot ROM overlay on, and clears the DSP index latch and all port bytes to 0.
- R2: An address outside 0x00F0–0x00FF, and outside the active overlay for reads, reaches the RAM: `ram_addr` equals the CPU address, and `ram_en` is high in the access cycle. The read data returns on `cpu_rdata` with `cpu_rvalid` high in the cycle that follows.
- R3: An access to 0x00F0–0x00FF never asserts `ram_en` or `ram_we`.
- R4: A read from 0xFFC0–0xFFFF while control bit 7 is 1 returns ROM byte i = address bits [5:0], with value ((i*29) mod 256) XOR 0xA5. While bit 7 is 0, the same read returns RAM.
- R5: A write to 0xFFC0–0xFFFF always goes to RAM, whatever the overlay setting.
- R6: A write to 0x00F1 loads data bits [2:0] onto `timer_en` and data bit 7 into the overlay enable. These hold until the next write to 0x00F1.
- R7: A write to 0x00F1 with bit 4 set zeroes inbound ports 0 and 1. With bit 5 set, it zeroes inbound ports 2 and 3. The clear wins over a host load in the same cycle, and it is not stored: later host loads land normally.
- R8: A write to 0x00F2 stores the full byte in the index latch. A read of 0x00F2 returns it, and `dsp_idx` always shows latch bits [6:0].
- R9: A write to 0x00F3 raises `dsp_we` for one cycle on the next cycle, with `dsp_wdata` equal to the data, unless latch bit 7 is 1, in which case the write is dropped. A read of 0x00F3 returns `dsp_rdata` as sampled in the read cycle.
- R10: A CPU write to 0x00F4+n (n = 0..3) sets byte n of `port_out` (bits 8n+7:8n) on the next cycle. A CPU read of 0x00F4+n returns the inbound byte n that was last loaded through `host_wr`, `host_sel`=n and `host_wdata`.
- R11: Reads of 0x00F0, 0x00F1 and 0x00F8–0x00FF return 0. Writes to 0x00F0 and 0x00F8–0x00FF change no output and no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, one cycle after the read |
| cpu_rvalid | output | 1 | Qualifies `cpu_rdata` |
| ram_addr | output | 16 | RAM address |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM synchronous read data |
| dsp_idx | output | 7 | DSP register index |
| dsp_we | output | 1 | DSP register write pulse |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_rdata | input | 8 | DSP register read data at `dsp_idx` |
| timer_en | output | 3 | Timer enables |
| host_wr | input | 1 | Host load strobe for an inbound port |
| host_sel | input | 2 | Inbound port number |
| host_wdata | input | 8 | Host byte |
| port_out | output | 32 | Outbound bytes, port n in bits 8n+7:8n |

## Verification
The bench first checks that a write into the overlay region lands in RAM while the overlay is on. It then reads the same address back after the overlay is turned off. A decoder that let the ROM swallow writes would return stale RAM at that point.

Several port cases are covered. The bench clears a port pair while the host loads one of the cleared ports in the same cycle, and expects zero. It then loads a port after a clear, which fails if the clear bit were held in the register.

On the DSP window, the bench reads the data port directly after a data write and expects the old value. It then writes with latch bit 7 set and expects the write to be dropped and later reads to mirror index bits [6:0].

Throughout the run, a design that touched RAM for a register-page access, or that returned anything but zero from a write-only register, shows up on the same cycle or the following one.

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;
  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_ROM = 2'd1,
    TGT_REG = 2'd2
  } tgt_e;

  // Offsets inside the register page
  localparam logic [3:0] OFF_TEST  = 4'h0;
  localparam logic [3:0] OFF_CTRL  = 4'h1;
  localparam logic [3:0] OFF_DIDX  = 4'h2;
  localparam logic [3:0] OFF_DDAT  = 4'h3;
  localparam logic [3:0] OFF_PORT0 = 4'h4;

  // Control register bit positions
  localparam int CTL_CLR_BASE = 4;  // bit 4: ports 0/1, bit 5: ports 2/3
  localparam int CTL_ROM_BIT  = 7;
endpackage

// File: rtl/snd_boot_rom.sv
module snd_boot_rom #(
  parameter int          AW   = 6,
  parameter int          DW   = 8,
  parameter logic [7:0]  SEED = 8'hA5
) (
  input  logic          clk,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] rom [DEPTH];

  // Contents derived from the index; replace SEED to re-key the image
  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = DW'(i * 29) ^ DW'(SEED);
  end

  always_ff @(posedge clk) begin
    if (rd) q <= rom[addr];
  end
endmodule

// File: rtl/snd_reg_file.sv
module snd_reg_file
  import snd_dec_pkg::*;
#(
  parameter int DW = 8,
  parameter int NP = 4,
  parameter int NT = 3,
  parameter int IW = 7,
  localparam int SW = $clog2(NP)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           acc_wr,
  input  logic [3:0]     acc_off,
  input  logic [DW-1:0]  acc_wdata,
  input  logic           host_wr,
  input  logic [SW-1:0]  host_sel,
  input  logic [DW-1:0]  host_wdata,
  input  logic [DW-1:0]  dsp_rdata,
  output logic [DW-1:0]  rd_data,
  output logic [NT-1:0]  timer_en,
  output logic           rom_en,
  output logic [NP*DW-1:0] port_out,
  output logic [IW-1:0]  dsp_idx,
  output logic           dsp_we,
  output logic [DW-1:0]  dsp_wdata
);
  logic          wr_ctrl, wr_didx, wr_ddat;
  logic [DW-1:0] didx_q;
  logic [DW-1:0] in_q  [NP];
  logic [DW-1:0] out_q [NP];
  logic [NP-1:0] clr;

  assign wr_ctrl = acc_wr && (acc_off == OFF_CTRL);
  assign wr_didx = acc_wr && (acc_off == OFF_DIDX);
  assign wr_ddat = acc_wr && (acc_off == OFF_DDAT);

  // Control register: enables stored, clear bits act on the write only
  always_ff @(posedge clk) begin
    if (rst) begin
      timer_en <= '0;
      rom_en   <= 1'b1;
    end else if (wr_ctrl) begin
      timer_en <= acc_wdata[NT-1:0];
      rom_en   <= acc_wdata[CTL_ROM_BIT];
    end
  end

  // DSP index latch and write pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      didx_q    <= '0;
      dsp_we    <= 1'b0;
      dsp_wdata <= '0;
    end else begin
      if (wr_didx) didx_q <= acc_wdata;
      dsp_we <= wr_ddat && !didx_q[DW-1];
      if (wr_ddat) dsp_wdata <= acc_wdata;
    end
  end
  assign dsp_idx = didx_q[IW-1:0];

  // Communication ports
  for (genvar i = 0; i < NP; i++) begin : g_port
    assign clr[i] = wr_ctrl && acc_wdata[CTL_CLR_BASE + i/2];

    always_ff @(posedge clk) begin
      if (rst)                                in_q[i] <= '0;
      else if (clr[i])                        in_q[i] <= '0;
      else if (host_wr && host_sel == SW'(i)) in_q[i] <= host_wdata;
    end

    always_ff @(posedge clk) begin
      if (rst) out_q[i] <= '0;
      else if (acc_wr && acc_off == 4'(OFF_PORT0 + i)) out_q[i] <= acc_wdata;
    end

    assign port_out[i*DW +: DW] = out_q[i];
  end

  always_comb begin
    rd_data = '0;
    if (acc_off == OFF_DIDX) rd_data = didx_q;
    if (acc_off == OFF_DDAT) rd_data = dsp_rdata;
    for (int i = 0; i < NP; i++) begin
      if (acc_off == 4'(OFF_PORT0 + i)) rd_data = in_q[i];
    end
  end

  // R1: reset leaves overlay on and timers off
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> rom_en && (timer_en == '0) && (didx_q == '0));

  // R6: enables move only on a control write
  p_timer_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(timer_en) && $stable(rom_en));

  // R7: pair clear zeroes both inbound bytes
  p_clear_lo_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && acc_wdata[CTL_CLR_BASE]) |=> (in_q[0] == '0) && (in_q[1] == '0));

  // R9: data write with index bit 7 set never reaches the DSP
  p_dsp_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_ddat && didx_q[DW-1]) |=> !dsp_we);
endmodule

// File: rtl/snd_bus_decoder.sv
module snd_bus_decoder
  import snd_dec_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         DATA_W   = 8,
  parameter int         ROM_AW   = 6,
  parameter int         NPORTS   = 4,
  parameter int         NTIMERS  = 3,
  parameter int         DSP_IW   = 7,
  parameter int         REG_PAGE = 'h00F,
  parameter logic [7:0] ROM_SEED = 8'hA5,
  localparam int        SW       = $clog2(NPORTS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic                     cpu_rd,
  input  logic                     cpu_wr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  output logic [DATA_W-1:0]        cpu_rdata,
  output logic                     cpu_rvalid,
  output logic [ADDR_W-1:0]        ram_addr,
  output logic                     ram_en,
  output logic                     ram_we,
  output logic [DATA_W-1:0]        ram_wdata,
  input  logic [DATA_W-1:0]        ram_rdata,
  output logic [DSP_IW-1:0]        dsp_idx,
  output logic                     dsp_we,
  output logic [DATA_W-1:0]        dsp_wdata,
  input  logic [DATA_W-1:0]        dsp_rdata,
  output logic [NTIMERS-1:0]       timer_en,
  input  logic                     host_wr,
  input  logic [SW-1:0]            host_sel,
  input  logic [DATA_W-1:0]        host_wdata,
  output logic [NPORTS*DATA_W-1:0] port_out
);
  localparam logic [ADDR_W-5:0] PAGE_TAG = (ADDR_W-4)'(REG_PAGE);

  logic              pg_hit, ovl_hit, rom_en;
  tgt_e              tgt, rd_tgt_q;
  logic [DATA_W-1:0] reg_rd, reg_q, rom_q;

  assign pg_hit  = cpu_addr[ADDR_W-1:4] == PAGE_TAG;
  assign ovl_hit = &cpu_addr[ADDR_W-1:ROM_AW];

  always_comb begin
    if (pg_hit)                 tgt = TGT_REG;
    else if (ovl_hit && rom_en) tgt = TGT_ROM;
    else                        tgt = TGT_RAM;
  end

  // RAM port: writes bypass the overlay, reads only when RAM is chosen
  assign ram_addr  = cpu_addr;
  assign ram_wdata = cpu_wdata;
  assign ram_we    = cpu_wr && !pg_hit;
  assign ram_en    = ram_we || (cpu_rd && tgt == TGT_RAM);

  snd_boot_rom #(
    .AW   (ROM_AW),
    .DW   (DATA_W),
    .SEED (ROM_SEED)
  ) u_rom (
    .clk  (clk),
    .rd   (cpu_rd && tgt == TGT_ROM),
    .addr (cpu_addr[ROM_AW-1:0]),
    .q    (rom_q)
  );

  snd_reg_file #(
    .DW (DATA_W),
    .NP (NPORTS),
    .NT (NTIMERS),
    .IW (DSP_IW)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .acc_wr     (cpu_wr && pg_hit),
    .acc_off    (cpu_addr[3:0]),
    .acc_wdata  (cpu_wdata),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .dsp_rdata  (dsp_rdata),
    .rd_data    (reg_rd),
    .timer_en   (timer_en),
    .rom_en     (rom_en),
    .port_out   (port_out),
    .dsp_idx    (dsp_idx),
    .dsp_we     (dsp_we),
    .dsp_wdata  (dsp_wdata)
  );

  // Read return stage
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rvalid <= 1'b0;
      rd_tgt_q   <= TGT_RAM;
      reg_q      <= '0;
    end else begin
      cpu_rvalid <= cpu_rd;
      if (cpu_rd) begin
        rd_tgt_q <= tgt;
        reg_q    <= reg_rd;
      end
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rvalid) begin
      case (rd_tgt_q)
        TGT_ROM: cpu_rdata = rom_q;
        TGT_REG: cpu_rdata = reg_q;
        default: cpu_rdata = ram_rdata;
      endcase
    end
  end

  // R2: one access per cycle, and every read is answered next cycle
  p_one_access_r2: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rd && cpu_wr));
  p_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_rd |=> cpu_rvalid);

  // R3: register page stays off the RAM port
  p_regpage_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[ADDR_W-1:4] == PAGE_TAG) |-> !ram_en);

  // R5: overlay writes always reach RAM
  p_ovl_write_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && ovl_hit) |-> ram_en && ram_we && (ram_addr == cpu_addr));
endmodule

// File: tb/snd_bus_decoder_bench.sv
module snd_bus_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        cpu_rvalid;
  logic [15:0] ram_addr;
  logic        ram_en, ram_we;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [6:0]  dsp_idx;
  logic        dsp_we;
  logic [7:0]  dsp_wdata, dsp_rdata;
  logic [2:0]  timer_en;
  logic        host_wr;
  logic [1:0]  host_sel;
  logic [7:0]  host_wdata;
  logic [31:0] port_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_bus_decoder u_snd_bus_decoder (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .ram_addr(ram_addr), .ram_en(ram_en), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .dsp_idx(dsp_idx), .dsp_we(dsp_we), .dsp_wdata(dsp_wdata),
    .dsp_rdata(dsp_rdata), .timer_en(timer_en), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .port_out(port_out)
  );

  // Environment: synchronous RAM and DSP register file
  bit [7:0] ram_mem [int];
  bit [7:0] dsp_mem [128];

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) ram_mem[int'(ram_addr)] = ram_wdata;
      else ram_rdata <= ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 8'h00;
    end
    if (dsp_we) dsp_mem[dsp_idx] = dsp_wdata;
  end
  assign dsp_rdata = dsp_mem[dsp_idx];

  // Reference model state
  bit [7:0] m_ram [int];
  bit [7:0] m_dsp [128];
  bit [7:0] m_in  [4];
  bit [7:0] m_out [4];
  bit [7:0] m_lat;
  bit [2:0] m_ten;
  bit       m_rom;
  bit       pa_v, pb_v;
  bit [6:0] pa_i, pb_i;
  bit [7:0] pa_d, pb_d;

  int nchk = 0, nerr = 0;
  bit done = 0;

  function automatic bit [7:0] rom_ref(input int i);
    return 8'((i * 29) % 256) ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit rd, input bit wr, input bit [15:0] a, input bit [7:0] d,
                      input bit hw, input bit [1:0] hs, input bit [7:0] hd, input string tag);
    bit       page = (a[15:4] == 12'h00F);
    bit [7:0] exp_rd = 8'h00;
    bit       exp_dwe;
    bit [7:0] ctl_clr = 8'h00;
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    host_wr = hw; host_sel = hs; host_wdata = hd;
    // DSP writes issued two steps ago are visible now
    if (pa_v) m_dsp[pa_i] = pa_d;
    if (page) begin
      case (a[3:0])
        4'h2: exp_rd = m_lat;
        4'h3: exp_rd = m_dsp[m_lat[6:0]];
        4'h4, 4'h5, 4'h6, 4'h7: exp_rd = m_in[a[1:0]];
        default: exp_rd = 8'h00;
      endcase
    end else if (a >= 16'hFFC0 && m_rom) exp_rd = rom_ref(int'(a[5:0]));
    else exp_rd = m_ram.exists(int'(a)) ? m_ram[int'(a)] : 8'h00;
    exp_dwe = wr && page && a[3:0] == 4'h3 && !m_lat[7];
    pa_v = pb_v; pa_i = pb_i; pa_d = pb_d;
    pb_v = exp_dwe; pb_i = m_lat[6:0]; pb_d = d;
    if (wr) begin
      if (!page) m_ram[int'(a)] = d;
      else begin
        case (a[3:0])
          4'h1: begin m_ten = d[2:0]; m_rom = d[7]; ctl_clr = d; end
          4'h2: m_lat = d;
          4'h4, 4'h5, 4'h6, 4'h7: m_out[a[1:0]] = d;
          default: ;
        endcase
      end
    end
    if (hw && !(hs < 2 ? ctl_clr[4] : ctl_clr[5])) m_in[hs] = hd;
    if (ctl_clr[4]) begin m_in[0] = 0; m_in[1] = 0; end
    if (ctl_clr[5]) begin m_in[2] = 0; m_in[3] = 0; end
    #1;
    if (page) chk("R3 ram_en", {31'd0, ram_en}, 32'd0);
    else if (rd || wr) begin
      chk("R2 ram_en", {31'd0, ram_en}, {31'd0, wr || !(a >= 16'hFFC0 && m_rom) || !rd});
      chk("R5 ram_we", {31'd0, ram_we}, {31'd0, wr});
    end
    @(negedge clk);
    chk("R6 timer_en", {29'd0, timer_en}, {29'd0, m_ten});
    chk("R10 port_out", port_out, {m_out[3], m_out[2], m_out[1], m_out[0]});
    chk("R8 dsp_idx", {25'd0, dsp_idx}, {25'd0, m_lat[6:0]});
    chk("R9 dsp_we", {31'd0, dsp_we}, {31'd0, exp_dwe});
    if (exp_dwe) chk("R9 dsp_wdata", {24'd0, dsp_wdata}, {24'd0, d});
    if (rd) begin
      chk("R2 cpu_rvalid", {31'd0, cpu_rvalid}, 32'd1);
      chk(tag, {24'd0, cpu_rdata}, {24'd0, exp_rd});
    end
    cpu_rd = 0; cpu_wr = 0; host_wr = 0;
  endtask

  task automatic rdx(input bit [15:0] a, input string tag);
    step(1, 0, a, 8'h00, 0, 2'd0, 8'h00, tag);
  endtask
  task automatic wrx(input bit [15:0] a, input bit [7:0] d, input string tag);
    step(0, 1, a, d, 0, 2'd0, 8'h00, tag);
  endtask
  task automatic host(input bit [1:0] s, input bit [7:0] d);
    step(0, 0, 16'h0000, 8'h00, 1, s, d, "R10");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst = 1; cpu_rd = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
    host_wr = 0; host_sel = 0; host_wdata = 0;
    m_lat = 0; m_ten = 0; m_rom = 1;
    pa_v = 0; pb_v = 0; pa_i = 0; pb_i = 0; pa_d = 0; pb_d = 0;
    for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_out[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 timer_en", {29'd0, timer_en}, 32'd0);
    chk("R1 port_out", port_out, 32'd0);
    chk("R1 dsp_idx", {25'd0, dsp_idx}, 32'd0);
    rdx(16'hFFC0, "R1 overlay on");
    // R4: overlay reads
    rdx(16'hFFFF, "R4 rom top");
    rdx(16'hFFE3, "R4 rom mid");
    // R5: write under overlay, then turn overlay off
    wrx(16'hFFC5, 8'h3C, "R5");
    rdx(16'hFFC5, "R4 rom hides ram");
    wrx(16'h00F1, 8'h00, "R6");
    rdx(16'hFFC5, "R5 ram under overlay");
    rdx(16'hFFC6, "R4 ram when off");
    // R2: plain RAM
    wrx(16'h0000, 8'h11, "R2"); wrx(16'h1234, 8'h5A, "R2");
    wrx(16'hFFBF, 8'hC3, "R2"); wrx(16'h00EF, 8'h7E, "R2");
    wrx(16'h0100, 8'h99, "R2");
    rdx(16'h1234, "R2 ram"); rdx(16'h0000, "R2 ram"); rdx(16'hFFBF, "R2 ram edge");
    rdx(16'h00EF, "R2 below page"); rdx(16'h0100, "R2 above page");
    // R11: unused and write-only registers
    wrx(16'h00F8, 8'h77, "R11"); rdx(16'h00F8, "R11 f8 zero");
    wrx(16'h00FF, 8'hEE, "R11"); rdx(16'h00FF, "R11 ff zero");
    // R6: control register
    wrx(16'h00F1, 8'h05, "R6");
    wrx(16'h00F1, 8'h87, "R6");
    rdx(16'h00F1, "R11 ctrl zero");
    rdx(16'hFFC1, "R6 overlay back on");
    wrx(16'h00F0, 8'hFF, "R11");
    rdx(16'h00F0, "R11 test zero");
    // R10: ports both ways
    host(2'd0, 8'hA1); host(2'd1, 8'hB2); host(2'd2, 8'hC3); host(2'd3, 8'hD4);
    for (int n = 0; n < 4; n++) rdx(16'(16'h00F4 + n), "R10 inbound");
    for (int n = 0; n < 4; n++) wrx(16'(16'h00F4 + n), 8'(8'h30 + n * 17), "R10");
    step(1, 0, 16'h00F5, 8'h00, 1, 2'd1, 8'h44, "R10 old before load");
    rdx(16'h00F5, "R10 new after load");
    // R7: pair clears
    wrx(16'h00F1, 8'h90, "R7");
    for (int n = 0; n < 4; n++) rdx(16'(16'h00F4 + n), "R7 lo pair");
    step(0, 1, 16'h00F1, 8'hA0, 1, 2'd2, 8'h5E, "R7");
    rdx(16'h00F6, "R7 clear beats host");
    rdx(16'h00F7, "R7 hi pair");
    host(2'd0, 8'h6D);
    rdx(16'h00F4, "R7 clear not held");
    // R8 / R9: DSP window
    wrx(16'h00F2, 8'h15, "R8");
    rdx(16'h00F2, "R8 latch read");
    wrx(16'h00F3, 8'h66, "R9");
    rdx(16'h00F3, "R9 read old");
    rdx(16'h00F3, "R9 read new");
    wrx(16'h00F2, 8'h95, "R8");
    rdx(16'h00F2, "R8 full byte");
    wrx(16'h00F3, 8'h11, "R9 dropped");
    step(0, 0, 16'h0000, 8'h00, 0, 2'd0, 8'h00, "R9");
    rdx(16'h00F3, "R9 mirror no write");
    wrx(16'h00F2, 8'h40, "R8");
    wrx(16'h00F3, 8'hE7, "R9");
    step(0, 0, 16'h0000, 8'h00, 0, 2'd0, 8'h00, "R9");
    rdx(16'h00F3, "R9 other index");
    // R11: writes to the test register left everything alone
    rdx(16'h00F7, "R11 ports intact");
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule